// File: doc/BRIEF.md
# Two-Port Read/Write Memory with Per-Port Write Read-Back Modes

This block is a single-clock memory with two equal ports, A and B. Either port may read or write on any cycle through its own address, write strobe and write data. Each port has its own registered read output, so data appears one clock after the address is presented. On a cycle where a port writes, it also reads the same location. A per-port parameter chooses what that port's output shows on such a cycle:

- the value just written;
- the value the location held before the write;
- the port's previous output, left unchanged.

The block compares the two port addresses on every cycle and resolves same-address access in a fixed way. When both ports write one location, port A's data is stored. When one port writes and the other only reads that location, the reader receives the new data. In both cases a collision flag is raised for one cycle, aligned with the read data of that access. A synchronous reset clears the read outputs and the flag but leaves the stored contents alone.

The data path has no sequencer. Each port's output select is a small enumerated decision with three values: FRESH (post-write value), OLD (pre-write value) and HOLD (keep the register). The address comparator classifies every cycle as one of four collision kinds:
- NONE: no shared-address hazard;
- WW: both ports write the same address;
- AW_BR: A writes and B reads the same address;
- BW_AR: B writes and A reads the same address.

Top module: `tdp_ram`

## Requirements
- R1: Read latency is one clock. The address and write strobe sampled at a rising edge determine the read output visible after that edge. Each port reads and writes independently of the other when the addresses differ.
- R2: A port whose mode parameter is 0 (write-first) shows, after a cycle in which it writes, the value stored by that write. For port B in a same-address double write, that stored value is port A's data.
- R3: A port whose mode parameter is 1 (read-first) shows, after a cycle in which it writes, the contents the location held before that write.
- R4: A port whose mode parameter is 2 (no-change) keeps its read output unchanged across a cycle in which it writes.
- R5: A port that does not write shows the stored contents of its address. Writes from the two ports to different addresses are both stored.
- R6: When both ports write the same address in the same cycle, port A's data is what is stored. A later read from either port returns it.
- R7: When one port writes and the other port reads the same address in the same cycle, the reading port's output shows the newly written data.
- R8: The collision output is 1 for exactly the cycle after an edge at which the two addresses were equal and at least one port wrote. It is 0 otherwise, including when both ports only read the same address.
- R9: A synchronous reset drives both read outputs and the collision output to 0 after the edge. The stored contents are preserved and read back unchanged after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for both ports |
| rst | input | 1 | Synchronous reset of the read outputs and collision flag |
| a_we | input | 1 | Port A write strobe |
| a_addr | input | ADDR_W (9) | Port A address |
| a_wdata | input | DATA_W (18) | Port A write data |
| a_rdata | output | DATA_W (18) | Port A registered read data |
| b_we | input | 1 | Port B write strobe |
| b_addr | input | ADDR_W (9) | Port B address |
| b_wdata | input | DATA_W (18) | Port B write data |
| b_rdata | output | DATA_W (18) | Port B registered read data |
| collision | output | 1 | One-cycle flag for a same-address access with at least one write |

## Verification
Two instances receive identical stimulus. One uses write-first on A and read-first on B; the other uses no-change on A and write-first on B. A single write therefore separates all three read-back modes at once.

The stimulus covers four kinds of cycle:
- Writes to distinct addresses, which separate independent port operation from any cross-port effect.
- Same-address double writes, which show whether A's data wins and how B's write-first output follows it.
- One-sided writes against a read on the other port, which show whether forwarding or stale array data reaches the reader.
- Same-address reads with no write, which must leave the flag low.

A mid-run reset followed by read-back separates clearing the outputs from clearing the array. A long random mix over eight addresses then exercises the collision rules in many combinations.

// File: rtl/tdp_pkg.sv
package tdp_pkg;

    // Per-port read-back behaviour on a cycle the port writes
    typedef enum logic [1:0] {
        RDW_NEW  = 2'd0,   // write-first
        RDW_OLD  = 2'd1,   // read-first
        RDW_HOLD = 2'd2    // no-change
    } rdw_mode_e;

    // Classification of the two ports' accesses in one cycle
    typedef enum logic [1:0] {
        CLASH_NONE  = 2'd0,
        CLASH_WW    = 2'd1,
        CLASH_AW_BR = 2'd2,
        CLASH_BW_AR = 2'd3
    } clash_e;

    // Output register source select
    typedef enum logic [1:0] {
        OSEL_FRESH = 2'd0,
        OSEL_OLD   = 2'd1,
        OSEL_HOLD  = 2'd2
    } out_sel_e;

endpackage

// File: rtl/tdp_clash_detect.sv
module tdp_clash_detect
    import tdp_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    output clash_e            kind
);

    logic same_addr;

    assign same_addr = (a_addr == b_addr);

    always_comb begin
        kind = CLASH_NONE;
        if (same_addr) begin
            if (a_we && b_we)
                kind = CLASH_WW;
            else if (a_we)
                kind = CLASH_AW_BR;
            else if (b_we)
                kind = CLASH_BW_AR;
            else
                kind = CLASH_NONE;
        end
    end

endmodule

// File: rtl/tdp_store.sv
module tdp_store #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] a_old,
    output logic [DATA_W-1:0] b_old
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Pre-write contents at each port's address
    assign a_old = cells[a_addr];
    assign b_old = cells[b_addr];

    // Port B is applied first so that port A overrides it on an equal address
    always_ff @(posedge clk) begin
        if (b_we)
            cells[b_addr] <= b_wdata;
        if (a_we)
            cells[a_addr] <= a_wdata;
    end

endmodule

// File: rtl/tdp_port_out.sv
module tdp_port_out
    import tdp_pkg::*;
#(
    parameter int        DATA_W = 18,
    parameter rdw_mode_e MODE   = RDW_NEW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] old_data,
    input  logic [DATA_W-1:0] fresh_data,
    output logic [DATA_W-1:0] rdata
);

    out_sel_e sel;

    // Source decision
    always_comb begin
        if (!we) begin
            sel = OSEL_FRESH;
        end else begin
            unique case (MODE)
                RDW_NEW:  sel = OSEL_FRESH;
                RDW_OLD:  sel = OSEL_OLD;
                RDW_HOLD: sel = OSEL_HOLD;
                default:  sel = OSEL_FRESH;
            endcase
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else begin
            unique case (sel)
                OSEL_FRESH: rdata <= fresh_data;
                OSEL_OLD:   rdata <= old_data;
                OSEL_HOLD:  rdata <= rdata;
                default:    rdata <= fresh_data;
            endcase
        end
    end

    // R3: read-first output equals the pre-write array value
    a_r3_old_on_write: assert property (@(posedge clk) disable iff (rst)
        (MODE == RDW_OLD && $past(we) && !$past(rst)) |-> rdata == $past(old_data));

endmodule

// File: rtl/tdp_ram.sv
module tdp_ram
    import tdp_pkg::*;
#(
    parameter int        DATA_W = 18,
    parameter int        ADDR_W = 9,
    parameter rdw_mode_e MODE_A = RDW_NEW,
    parameter rdw_mode_e MODE_B = RDW_OLD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              collision
);

    clash_e            kind;
    logic [DATA_W-1:0] a_old;
    logic [DATA_W-1:0] b_old;
    logic [DATA_W-1:0] a_fresh;
    logic [DATA_W-1:0] b_fresh;

    tdp_clash_detect #(.ADDR_W(ADDR_W)) u_clash (
        .a_we   (a_we),
        .a_addr (a_addr),
        .b_we   (b_we),
        .b_addr (b_addr),
        .kind   (kind)
    );

    tdp_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .a_we    (a_we),
        .a_addr  (a_addr),
        .a_wdata (a_wdata),
        .b_we    (b_we),
        .b_addr  (b_addr),
        .b_wdata (b_wdata),
        .a_old   (a_old),
        .b_old   (b_old)
    );

    // Post-write value seen at each address after resolution (A wins)
    always_comb begin
        unique case (kind)
            CLASH_WW, CLASH_AW_BR: begin
                a_fresh = a_wdata;
                b_fresh = a_wdata;
            end
            CLASH_BW_AR: begin
                a_fresh = b_wdata;
                b_fresh = b_wdata;
            end
            default: begin
                a_fresh = a_we ? a_wdata : a_old;
                b_fresh = b_we ? b_wdata : b_old;
            end
        endcase
    end

    tdp_port_out #(.DATA_W(DATA_W), .MODE(MODE_A)) u_out_a (
        .clk        (clk),
        .rst        (rst),
        .we         (a_we),
        .old_data   (a_old),
        .fresh_data (a_fresh),
        .rdata      (a_rdata)
    );

    tdp_port_out #(.DATA_W(DATA_W), .MODE(MODE_B)) u_out_b (
        .clk        (clk),
        .rst        (rst),
        .we         (b_we),
        .old_data   (b_old),
        .fresh_data (b_fresh),
        .rdata      (b_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst)
            collision <= 1'b0;
        else
            collision <= (kind != CLASH_NONE);
    end

    // R8: the flag only follows a same-address access that includes a write
    a_r8_flag_has_cause: assert property (@(posedge clk) disable iff (rst)
        collision |-> $past(a_addr == b_addr && (a_we || b_we)));

    // R8: such an access always raises the flag
    a_r8_cause_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(a_addr == b_addr && (a_we || b_we))) |-> collision);

    // R2: write-first on A shows the data A wrote (A always wins)
    a_r2_a_write_first: assert property (@(posedge clk) disable iff (rst)
        (MODE_A == RDW_NEW && !$past(rst) && $past(a_we)) |-> a_rdata == $past(a_wdata));

    // R2: write-first on B shows its data unless A overwrote the same cell
    a_r2_b_write_first: assert property (@(posedge clk) disable iff (rst)
        (MODE_B == RDW_NEW && !$past(rst) && $past(b_we && !(a_we && a_addr == b_addr)))
        |-> b_rdata == $past(b_wdata));

    // R4: no-change keeps the output across an own write
    a_r4_a_hold: assert property (@(posedge clk) disable iff (rst)
        (MODE_A == RDW_HOLD && !$past(rst) && $past(a_we)) |-> $stable(a_rdata));

    a_r4_b_hold: assert property (@(posedge clk) disable iff (rst)
        (MODE_B == RDW_HOLD && !$past(rst) && $past(b_we)) |-> $stable(b_rdata));

    // R7: reading port receives the other port's new data
    a_r7_fwd_to_a: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(b_we && !a_we && a_addr == b_addr)) |-> a_rdata == $past(b_wdata));

    a_r7_fwd_to_b: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(a_we && !b_we && a_addr == b_addr)) |-> b_rdata == $past(a_wdata));

endmodule

// File: tb/tdp_ram_bench.sv
module tdp_ram_bench;
    import tdp_pkg::*;

    localparam int DW = 18;
    localparam int AW = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          a_we = 1'b0, b_we = 1'b0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] a_rd0, b_rd0, a_rd1, b_rd1;
    logic          coll0, coll1;

    always #10 clk = ~clk;   // 50 MHz

    // Instance 0: A write-first, B read-first
    tdp_ram #(.DATA_W(DW), .ADDR_W(AW), .MODE_A(RDW_NEW), .MODE_B(RDW_OLD)) u_tdp_ram (
        .clk(clk), .rst(rst),
        .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rd0),
        .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rd0),
        .collision(coll0));

    // Instance 1: A no-change, B write-first
    tdp_ram #(.DATA_W(DW), .ADDR_W(AW), .MODE_A(RDW_HOLD), .MODE_B(RDW_NEW)) u_tdp_ram_nc (
        .clk(clk), .rst(rst),
        .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rd1),
        .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rd1),
        .collision(coll1));

    typedef struct {
        logic [DW-1:0] ea0, eb0, ea1, eb1;
        logic          ec;
        int            tag;
    } exp_t;

    exp_t          sb[$];
    logic [DW-1:0] mdl [1 << AW];
    logic [DW-1:0] pa1, pb1;
    int            total = 0;
    int            bad   = 0;

    function automatic string tname(int t);
        case (t)
            1: return "R1";  2: return "R2";  3: return "R3";
            4: return "R4";  5: return "R5";  6: return "R6";
            7: return "R7";  8: return "R8";  9: return "R9";
            default: return "R?";
        endcase
    endfunction

    task automatic chk(int tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tname(tag), what, act, exp);
        end
    endtask

    // Driver: apply one cycle and push the expected outcome
    task automatic cyc(logic wa, logic [AW-1:0] aa, logic [DW-1:0] da,
                       logic wb, logic [AW-1:0] ab, logic [DW-1:0] db, int tag);
        exp_t e;
        logic [DW-1:0] oldb, fa, fb;
        @(negedge clk);
        rst = 1'b0;
        a_we = wa; a_addr = aa; a_wdata = da;
        b_we = wb; b_addr = ab; b_wdata = db;
        oldb = mdl[ab];
        if (wb) mdl[ab] = db;
        if (wa) mdl[aa] = da;   // A wins on equal address
        fa = mdl[aa];
        fb = mdl[ab];
        e.ec  = (aa == ab) && (wa || wb);
        e.ea0 = fa;
        e.eb0 = wb ? oldb : fb;
        e.ea1 = wa ? pa1 : fa;
        e.eb1 = fb;
        pa1 = e.ea1; pb1 = e.eb1;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic do_reset(int tag);
        exp_t e;
        @(negedge clk);
        rst = 1'b1; a_we = 1'b0; b_we = 1'b0;
        e.ea0 = '0; e.eb0 = '0; e.ea1 = '0; e.eb1 = '0; e.ec = 1'b0; e.tag = tag;
        pa1 = '0; pb1 = '0;
        sb.push_back(e);
    endtask

    // Monitor: compare once the edge has settled
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(e.tag, "i0.a_rdata", a_rd0, e.ea0);
            chk(e.tag, "i0.b_rdata", b_rd0, e.eb0);
            chk(e.tag, "i1.a_rdata", a_rd1, e.ea1);
            chk(e.tag, "i1.b_rdata", b_rd1, e.eb1);
            chk(e.tag, "i0.collision", {{(DW-1){1'b0}}, coll0}, {{(DW-1){1'b0}}, e.ec});
            chk(e.tag, "i1.collision", {{(DW-1){1'b0}}, coll1}, {{(DW-1){1'b0}}, e.ec});
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) mdl[i] = '0;
        pa1 = '0; pb1 = '0;
        repeat (2) @(posedge clk);
        do_reset(9);                                    // R9 reset state
        // Fill cells 0..15: A writes, B reads the same cell (R7, R8)
        for (int k = 0; k < 16; k++)
            cyc(1'b1, AW'(k), DW'(18'h100 + k), 1'b0, AW'(k), '0, 7);
        // Independent reads (R5, R1)
        cyc(1'b0, 9'd3, '0, 1'b0, 9'd12, '0, 5);
        cyc(1'b0, 9'd7, '0, 1'b0, 9'd2, '0, 1);
        // Writes to distinct addresses: modes separate (R2, R3, R4)
        cyc(1'b1, 9'd4, 18'h2AAAA, 1'b1, 9'd9, 18'h15555, 2);
        cyc(1'b1, 9'd5, 18'h00F0F, 1'b1, 9'd10, 18'h3C3C3, 3);
        cyc(1'b1, 9'd6, 18'h12345, 1'b0, 9'd1, '0, 4);
        cyc(1'b0, 9'd9, '0, 1'b0, 9'd4, '0, 5);         // R5 both landed
        // Same-address double write (R6, R2 on B)
        cyc(1'b1, 9'd8, 18'h3FFFF, 1'b1, 9'd8, 18'h00001, 6);
        cyc(1'b0, 9'd8, '0, 1'b0, 9'd8, '0, 6);         // R6 read-back, R8 no flag
        // One-sided write vs read (R7)
        cyc(1'b0, 9'd11, '0, 1'b1, 9'd11, 18'h0BEEF, 7);
        cyc(1'b1, 9'd12, 18'h1CAFE, 1'b0, 9'd12, '0, 7);
        // Same address, both read: no collision (R8)
        cyc(1'b0, 9'd12, '0, 1'b0, 9'd12, '0, 8);
        // Mid-run reset keeps contents (R9)
        do_reset(9);
        cyc(1'b0, 9'd11, '0, 1'b0, 9'd12, '0, 9);
        cyc(1'b0, 9'd8, '0, 1'b0, 9'd5, '0, 9);
        // Random mix over eight cells (R8 and all modes)
        for (int n = 0; n < 300; n++)
            cyc(1'($urandom), AW'($urandom % 8), DW'($urandom),
                1'($urandom), AW'($urandom % 8), DW'($urandom), 8);
        repeat (4) @(posedge clk);
        #5;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule